// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Postponement

This block decides when a DDR SDRAM command path should issue an AUTO REFRESH. A programmable interval timer produces one expiry per refresh interval, and a debt counter records how many refreshes are owed. Refresh has no address of its own at this level, because the device takes the row from its own internal counter. The block therefore hands the controller only a request and an urgency flag, and it receives a grant.

While the controller reports busy, the block holds back low-priority requests and lets the debt grow. Once the controller goes idle, it keeps its request raised every cycle, so owed refreshes drain back to back. When the debt reaches the postponement limit, an urgent request is raised whatever the busy hint says. The limit is eight in relaxed mode and seven in strict mode. If the controller grants urgent requests at once, the gap between two refreshes stays within nine intervals in relaxed mode and eight in strict mode.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted, `pend_o` is 0 and `ref_req_o`, `ref_urgent_o` and `ovf_o` are all low.
- R2: On the first rising clock edge after reset release, the block captures `period_i` as the interval P, with a value of 0 treated as 1. Later changes to `period_i` are ignored. The first expiry adds 1 to `pend_o` on the (P+1)th edge after release, and every later expiry adds 1 exactly P edges after the one before, whether or not grants arrive.
- R3: A cycle with `ref_grant_i` high while `ref_req_o` is high removes one owed refresh at the next edge. A grant in a cycle where `ref_req_o` is low has no effect on `pend_o`.
- R4: While `busy_i` is high and `pend_o` is below the limit, `ref_req_o` is low.
- R5: While `busy_i` is low and `pend_o` is nonzero, `ref_req_o` is high in every cycle, so consecutive grants drain the debt to zero back to back.
- R6: When `pend_o` equals the limit, `ref_urgent_o` and `ref_req_o` are high regardless of `busy_i`. Both stay high until a grant is received.
- R7: The limit is 8 when `strict_i` is 0 and 7 when `strict_i` is 1. `pend_o` never exceeds the limit.
- R8: An expiry that arrives while `pend_o` is at the limit and without a grant in the same cycle raises `ovf_o` for that cycle and leaves `pend_o` unchanged.
- R9: If the controller grants every urgent request in the cycle it appears, the gap between two granted refreshes never exceeds (limit+1)×P cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| period_i | input | PER_W (16) | Refresh interval in clock cycles, captured after reset |
| strict_i | input | 1 | 1 selects the tighter postponement limit (MAX_POST-1) |
| busy_i | input | 1 | Controller busy hint; defers low-priority requests |
| ref_grant_i | input | 1 | Controller accepts the refresh request this cycle |
| ref_req_o | output | 1 | Refresh requested |
| ref_urgent_o | output | 1 | Postponement limit reached; the refresh must be issued now |
| ovf_o | output | 1 | An interval expired with the debt already at the limit |
| pend_o | output | $clog2(MAX_POST+1) (4) | Number of owed refreshes |

## Verification
The bench builds the block with its defaults, MAX_POST=8 and a 16-bit period, and re-runs reset with intervals of 0, 1, 3, 4, 5, 6 and 7 cycles. The short intervals let the debt reach both the relaxed and the strict limit within a few dozen cycles. Withholding grants reaches the overflow case. Interval 1 puts an expiry and a grant into the same cycle repeatedly. Alternating long busy and idle stretches produce back-to-back drains and near-worst gaps between refreshes.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic {
    POST_RELAXED = 1'b0,
    POST_STRICT  = 1'b1
  } post_mode_e;

  // Number of refreshes that may be owed before the request turns urgent.
  function automatic int unsigned post_limit(int unsigned max_post, post_mode_e mode);
    return (mode == POST_STRICT) ? (max_post - 1) : max_post;
  endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);

  logic             loaded_q, loaded_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] eff_per;
  logic             load_en;

  always_comb begin
    eff_per  = (period_i == '0) ? PER_W'(1) : period_i;
    load_en  = !loaded_q;
    loaded_d = 1'b1;
    per_d    = eff_per;
    tick_o   = 1'b0;
    if (load_en) begin
      cnt_d = eff_per - PER_W'(1);
    end else if (cnt_q == '0) begin
      tick_o = 1'b1;
      cnt_d  = per_q - PER_W'(1);
    end else begin
      cnt_d = cnt_q - PER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      per_q    <= '0;
      cnt_q    <= '0;
    end else begin
      if (load_en) begin
        loaded_q <= loaded_d;
        per_q    <= per_d;
      end
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/refresh_debt_counter.sv
module refresh_debt_counter
  import refresh_pkg::*;
#(
  parameter int MAX_POST = 8,
  parameter int PEND_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              take_i,
  input  logic              strict_i,
  output logic [PEND_W-1:0] pend_o,
  output logic              at_limit_o,
  output logic              ovf_o
);

  localparam logic [PEND_W-1:0] LIM_RELAXED = PEND_W'(post_limit(MAX_POST, POST_RELAXED));
  localparam logic [PEND_W-1:0] LIM_STRICT  = PEND_W'(post_limit(MAX_POST, POST_STRICT));

  logic [PEND_W-1:0] pend_q, pend_d;
  logic [PEND_W-1:0] limit;
  logic              pend_en;

  always_comb begin
    limit      = strict_i ? LIM_STRICT : LIM_RELAXED;
    at_limit_o = (pend_q >= limit);
    ovf_o      = tick_i && !take_i && at_limit_o;
    pend_en    = 1'b0;
    pend_d     = pend_q;
    if (tick_i && !take_i && !at_limit_o) begin
      pend_en = 1'b1;
      pend_d  = pend_q + PEND_W'(1);
    end else if (!tick_i && take_i) begin
      pend_en = 1'b1;
      pend_d  = pend_q - PEND_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/refresh_req_gate.sv
module refresh_req_gate #(
  parameter int PEND_W = 4
) (
  input  logic [PEND_W-1:0] pend_i,
  input  logic              at_limit_i,
  input  logic              busy_i,
  input  logic              grant_i,
  output logic              req_o,
  output logic              urgent_o,
  output logic              take_o
);

  logic owed;

  always_comb begin
    owed     = (pend_i != '0);
    urgent_o = owed && at_limit_i;
    req_o    = owed && (!busy_i || at_limit_i);
    take_o   = req_o && grant_i;
  end

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int PER_W    = 16,
  parameter int MAX_POST = 8,
  localparam int PEND_W  = $clog2(MAX_POST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PER_W-1:0]  period_i,
  input  logic              strict_i,
  input  logic              busy_i,
  input  logic              ref_grant_i,
  output logic              ref_req_o,
  output logic              ref_urgent_o,
  output logic              ovf_o,
  output logic [PEND_W-1:0] pend_o
);

  logic tick_w;
  logic take_w;
  logic at_limit_w;

  refresh_interval_timer #(.PER_W(PER_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_i),
    .tick_o   (tick_w)
  );

  refresh_debt_counter #(.MAX_POST(MAX_POST), .PEND_W(PEND_W)) i_debt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_w),
    .take_i     (take_w),
    .strict_i   (strict_i),
    .pend_o     (pend_o),
    .at_limit_o (at_limit_w),
    .ovf_o      (ovf_o)
  );

  refresh_req_gate #(.PEND_W(PEND_W)) i_gate (
    .pend_i     (pend_o),
    .at_limit_i (at_limit_w),
    .busy_i     (busy_i),
    .grant_i    (ref_grant_i),
    .req_o      (ref_req_o),
    .urgent_o   (ref_urgent_o),
    .take_o     (take_w)
  );

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int MAX_POST = 8,
  parameter int PEND_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strict_i,
  input logic              busy_i,
  input logic              ref_grant_i,
  input logic              ref_req_o,
  input logic              ref_urgent_o,
  input logic              ovf_o,
  input logic [PEND_W-1:0] pend_o,
  input logic              tick_w
);

  // R7
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o <= PEND_W'(MAX_POST));

  // R6
  urgent_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent_o |-> ref_req_o);

  // R6
  urgent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_urgent_o && !ref_grant_i && $stable(strict_i)) |=> (ref_urgent_o || !$stable(strict_i)));

  // R4
  busy_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !ref_urgent_o) |-> !ref_req_o);

  // R3
  grant_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req_o && ref_grant_i && !tick_w) |=> (pend_o == $past(pend_o) - PEND_W'(1)));

  // R2
  tick_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_w && !(ref_req_o && ref_grant_i) && !ovf_o) |=> (pend_o == $past(pend_o) + PEND_W'(1)));

  // R8
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> $stable(pend_o));

endmodule

bind refresh_sched refresh_sched_chk #(.MAX_POST(MAX_POST), .PEND_W(PEND_W)) i_refresh_sched_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .strict_i     (strict_i),
  .busy_i       (busy_i),
  .ref_grant_i  (ref_grant_i),
  .ref_req_o    (ref_req_o),
  .ref_urgent_o (ref_urgent_o),
  .ovf_o        (ovf_o),
  .pend_o       (pend_o),
  .tick_w       (tick_w)
);

// File: tb/test_refresh_sched.sv
module test_refresh_sched;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_POST   = 8;
  localparam int PEND_W     = $clog2(MAX_POST + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic [15:0]       period_i;
  logic              strict_i;
  logic              busy_i;
  logic              ref_grant_i;
  logic              ref_req_o;
  logic              ref_urgent_o;
  logic              ovf_o;
  logic [PEND_W-1:0] pend_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int cyc = 0;

  // behavioural reference state
  int m_pend, m_cnt, m_per, lim, last_gnt;
  bit m_loaded;
  logic [15:0] lfsr;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_sched #(.PER_W(16), .MAX_POST(MAX_POST)) i_refresh_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_i     (period_i),
    .strict_i     (strict_i),
    .busy_i       (busy_i),
    .ref_grant_i  (ref_grant_i),
    .ref_req_o    (ref_req_o),
    .ref_urgent_o (ref_urgent_o),
    .ovf_o        (ovf_o),
    .pend_o       (pend_o)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic do_reset(int per, bit strict);
    @(negedge clk);
    rst_n       = 1'b0;
    period_i    = per[15:0];
    strict_i    = strict;
    busy_i      = 1'b1;
    ref_grant_i = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check("R1 pend in reset", int'(pend_o), 0);
    check("R1 req in reset", int'(ref_req_o), 0);
    check("R1 urgent in reset", int'(ref_urgent_o), 0);
    check("R1 ovf in reset", int'(ovf_o), 0);
    @(negedge clk);
    rst_n    = 1'b1;
    m_pend   = 0;
    m_cnt    = 0;
    m_per    = 0;
    m_loaded = 1'b0;
    lim      = strict ? MAX_POST - 1 : MAX_POST;
    last_gnt = -1;
  endtask

  // bmode: 0 busy, 1 idle, 2 random, 3 alternating 80-cycle stretches
  // gmode: 0 always grant, 1 grant urgent only, 2 never, 3 random
  task automatic run(int ncyc, int bmode, int gmode, bit gapchk);
    for (int i = 0; i < ncyc; i++) begin
      bit tick_m, urg_m, req_m, g, ovf_m;
      if (i == 1) period_i = 16'hBEEF;  // must be ignored once captured (R2)
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (bmode)
        0:       busy_i = 1'b1;
        1:       busy_i = 1'b0;
        2:       busy_i = lfsr[0];
        default: busy_i = ((i / 80) % 2) == 0;
      endcase
      #1;
      case (gmode)
        0:       ref_grant_i = 1'b1;
        1:       ref_grant_i = ref_urgent_o;
        2:       ref_grant_i = 1'b0;
        default: ref_grant_i = lfsr[3];
      endcase
      #1;
      tick_m = m_loaded && (m_cnt == 0);
      urg_m  = (m_pend >= lim);
      req_m  = (m_pend != 0) && (!busy_i || urg_m);
      g      = ref_grant_i && req_m;
      ovf_m  = tick_m && !g && urg_m;
      check("R2 R3 pend count", int'(pend_o), m_pend);
      check("R4 R5 request", int'(ref_req_o), int'(req_m));
      check("R6 urgent", int'(ref_urgent_o), int'(urg_m));
      check("R8 overflow", int'(ovf_o), int'(ovf_m));
      check("R7 pend within limit", int'(int'(pend_o) <= lim), 1);
      if (g) begin
        if (gapchk && last_gnt >= 0)
          check("R9 refresh gap bound", int'((cyc - last_gnt) <= (lim + 1) * m_per), 1);
        last_gnt = cyc;
      end
      if (!m_loaded) begin
        m_per    = (period_i == 16'd0) ? 1 : int'(period_i);
        m_cnt    = m_per - 1;
        m_loaded = 1'b1;
      end else if (m_cnt == 0) begin
        m_cnt = m_per - 1;
      end else begin
        m_cnt = m_cnt - 1;
      end
      if (tick_m && !g && !urg_m) m_pend = m_pend + 1;
      else if (!tick_m && g)      m_pend = m_pend - 1;
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n       = 1'b0;
    period_i    = 16'd6;
    strict_i    = 1'b0;
    busy_i      = 1'b1;
    ref_grant_i = 1'b0;
    lfsr        = 16'hACE1;
    // R6 R7: busy throughout, debt climbs to 8, urgent grants only
    do_reset(6, 1'b0);
    run(300, 0, 1, 1'b1);
    // R5 R9: long idle and busy stretches, controller grants whatever is asked
    do_reset(4, 1'b0);
    run(400, 3, 0, 1'b1);
    // R7 R9: strict limit of 7
    do_reset(5, 1'b1);
    run(300, 0, 1, 1'b1);
    run(200, 2, 0, 1'b1);
    // R8: no grants, then drain when idle (R5)
    do_reset(3, 1'b0);
    run(120, 0, 2, 1'b0);
    run(60, 1, 0, 1'b0);
    // R2 R3: expiry every cycle, expiry and grant in the same cycle
    do_reset(1, 1'b0);
    run(100, 0, 1, 1'b1);
    // R2: period 0 behaves as 1
    do_reset(0, 1'b0);
    run(50, 1, 0, 1'b1);
    // random busy and grant
    do_reset(7, 1'b0);
    run(600, 2, 3, 1'b0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule